// File: doc/BRIEF.md
# Dual Halfword Averager with Rounding

The block averages two 32-bit operands lane by lane. Each operand is split into two signed 16-bit lanes; for every lane the two values are summed at full precision and halved with an arithmetic shift. When that sum is odd, the half that is dropped can be put back according to a rounding direction. The direction comes from a 2-bit direction field, or from a single round-up bit, or is fixed toward negative infinity in legacy mode. The packed result appears one clock after a valid strobe.

A small output controller with two named states drives the result strobe. In `OUT_EMPTY` no result is presented. The transition LOAD (taken when `in_valid` is high) moves to `OUT_FULL`. In `OUT_FULL` a fresh result is presented. The transition DRAIN (taken when `in_valid` is low) returns to `OUT_EMPTY`. Otherwise the state holds. The result register only loads on `in_valid`, so it keeps the last answer while idle.

Top module: `halfword_avg_unit`

## Requirements
- R1: Lane 0 takes bits 15:0 of both operands and lane 1 takes bits 31:16. Each lane result is written back to the same bit positions. The two lanes do not affect each other.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and `out_result` then holds that operation's result. While `in_valid` is low, `out_result` keeps its last value.
- R3: While `rst` is high at a clock edge, `out_valid` and `out_result` are cleared to zero, whatever the other inputs are.
- R4: With `legacy_mode` = 1, each lane result is floor(sum/2), rounded toward negative infinity. `rnd_src_sel`, `rnd_dir` and `rnd_up` have no effect.
- R5: When a lane sum is even, the lane result is exactly sum/2 in every mode.
- R6: With `legacy_mode` = 0, `rnd_src_sel` = 1 and `rnd_dir` = 0 (nearest), an odd sum rounds its exact half toward positive infinity (floor + 1).
- R7: With `rnd_src_sel` = 1 and `rnd_dir` = 1 (toward zero), an odd sum gives floor + 1 when the sum is negative and floor when it is positive.
- R8: With `rnd_src_sel` = 1 and `rnd_dir` = 2 (toward positive infinity), an odd sum gives floor + 1.
- R9: With `rnd_src_sel` = 1 and `rnd_dir` = 3 (toward negative infinity), an odd sum gives floor.
- R10: With `legacy_mode` = 0 and `rnd_src_sel` = 0, an odd sum gives floor + 1 if `rnd_up` = 1 and floor if `rnd_up` = 0. `rnd_dir` is ignored in this case.
- R11: At the extremes of the lane range the result never wraps: 0x7FFF + 0x7FFF gives 0x7FFF, 0x8000 + 0x8000 gives 0x8000, and 0x7FFF + 0x7FFE rounded up gives 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| opnd_a | input | 32 | First operand, two signed 16-bit lanes |
| opnd_b | input | 32 | Second operand, two signed 16-bit lanes |
| legacy_mode | input | 1 | 1: always round toward negative infinity |
| rnd_src_sel | input | 1 | 1: direction comes from `rnd_dir`; 0: direction comes from `rnd_up` |
| rnd_dir | input | 2 | 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| rnd_up | input | 1 | Used when `rnd_src_sel` = 0: 1 toward +inf, 0 toward -inf |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Packed lane averages |

## Verification
The assertions assume that the operands and all four rounding controls are known, settled values in every cycle where `in_valid` is high. They sample those values only on such cycles. They also assume that the controls need no meaning while `in_valid` is low. The stimulus respects this in two ways. It changes every input only at the falling clock edge, and it sets operands and controls in the same step that raises `in_valid`. While idle it drives arbitrary controls with `in_valid` low, so the assertions are shown to ignore them.

// File: rtl/avg_pkg.sv
package avg_pkg;

    // Effective rounding direction; encoding matches the rnd_dir port field.
    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_ZERO    = 2'd1,
        RND_POS     = 2'd2,
        RND_NEG     = 2'd3
    } rnd_dir_e;

    // Output controller states.
    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/avg_mode_decode.sv
module avg_mode_decode
    import avg_pkg::*;
(
    input  logic       legacy_mode,
    input  logic       rnd_src_sel,
    input  logic [1:0] rnd_dir,
    input  logic       rnd_up,
    output rnd_dir_e   eff_dir
);

    // Legacy mode wins; then the source select picks field or single bit.
    always_comb begin
        if (legacy_mode) begin
            eff_dir = RND_NEG;
        end else if (rnd_src_sel) begin
            eff_dir = rnd_dir_e'(rnd_dir);
        end else begin
            eff_dir = rnd_up ? RND_POS : RND_NEG;
        end
    end

endmodule

// File: rtl/avg_lane.sv
module avg_lane
    import avg_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  rnd_dir_e          dir,
    output logic [LANE_W-1:0] res
);

    localparam int SUM_W = LANE_W + 1;

    logic signed [SUM_W-1:0] sum;
    logic [LANE_W-1:0]       prov;
    logic                    odd;
    logic                    neg;
    logic                    bump;

    // The sum gets one extra bit, so it never overflows.
    assign sum  = $signed({a[LANE_W-1], a}) + $signed({b[LANE_W-1], b});
    assign prov = sum[SUM_W-1:1];
    assign odd  = sum[0];
    assign neg  = sum[SUM_W-1];

    always_comb begin
        bump = 1'b0;
        if (odd) begin
            unique case (dir)
                RND_NEAREST: bump = 1'b1;
                RND_ZERO:    bump = neg;
                RND_POS:     bump = 1'b1;
                RND_NEG:     bump = 1'b0;
            endcase
        end
    end

    // An odd sum leaves prov at most max-1, so the increment cannot wrap.
    assign res = prov + {{(LANE_W-1){1'b0}}, bump};

endmodule

// File: rtl/halfword_avg_unit.sv
module halfword_avg_unit
    import avg_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic        legacy_mode,
    input  logic        rnd_src_sel,
    input  logic [1:0]  rnd_dir,
    input  logic        rnd_up,
    output logic        out_valid,
    output logic [31:0] out_result
);

    localparam int DATA_W = LANE_W * LANES;
    localparam int HI_LSB = DATA_W - LANE_W;

    rnd_dir_e          eff_dir;
    logic [DATA_W-1:0] lane_res;
    logic [DATA_W-1:0] result_q;
    out_state_e        state_q;
    out_state_e        state_d;

    avg_mode_decode u_decode (
        .legacy_mode (legacy_mode),
        .rnd_src_sel (rnd_src_sel),
        .rnd_dir     (rnd_dir),
        .rnd_up      (rnd_up),
        .eff_dir     (eff_dir)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        avg_lane #(.LANE_W(LANE_W)) u_lane (
            .a   (opnd_a[g*LANE_W +: LANE_W]),
            .b   (opnd_b[g*LANE_W +: LANE_W]),
            .dir (eff_dir),
            .res (lane_res[g*LANE_W +: LANE_W])
        );
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= OUT_EMPTY;
        else     state_q <= state_d;
    end

    // Next state: LOAD on in_valid, DRAIN without it
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: if (in_valid)  state_d = OUT_FULL;
            OUT_FULL:  if (!in_valid) state_d = OUT_EMPTY;
        endcase
    end

    // Output data register
    always_ff @(posedge clk) begin
        if (rst)           result_q <= '0;
        else if (in_valid) result_q <= lane_res;
    end

    assign out_valid  = (state_q == OUT_FULL);
    assign out_result = result_q;

    // Independent lane reference taken from the ports, for the checks below
    logic signed [LANE_W:0] chk_sum_lo;
    logic signed [LANE_W:0] chk_sum_hi;
    logic [LANE_W-1:0]      chk_floor_lo;
    logic [LANE_W-1:0]      chk_floor_hi;
    assign chk_sum_lo   = $signed({opnd_a[LANE_W-1], opnd_a[LANE_W-1:0]})
                        + $signed({opnd_b[LANE_W-1], opnd_b[LANE_W-1:0]});
    assign chk_sum_hi   = $signed({opnd_a[DATA_W-1], opnd_a[DATA_W-1:HI_LSB]})
                        + $signed({opnd_b[DATA_W-1], opnd_b[DATA_W-1:HI_LSB]});
    assign chk_floor_lo = chk_sum_lo[LANE_W:1];
    assign chk_floor_hi = chk_sum_hi[LANE_W:1];

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));

    a_r4_legacy_floor: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legacy_mode) |=> (out_result[LANE_W-1:0] == $past(chk_floor_lo)));

    a_r5_even_exact: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !chk_sum_lo[0]) |=> (out_result[LANE_W-1:0] == $past(chk_floor_lo)));

    a_r11_within_one: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((out_result[DATA_W-1:HI_LSB] == $past(chk_floor_hi)) ||
                      (out_result[DATA_W-1:HI_LSB] == $past(chk_floor_hi) + LANE_W'(1))));

endmodule

// File: tb/test_halfword_avg_unit.sv
`timescale 1ns/1ps
module test_halfword_avg_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        legacy_mode = 1'b0;
    logic        rnd_src_sel = 1'b0;
    logic [1:0]  rnd_dir = 2'd0;
    logic        rnd_up = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] last_exp = '0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    halfword_avg_unit i_halfword_avg_unit (
        .clk, .rst, .in_valid, .opnd_a, .opnd_b, .legacy_mode,
        .rnd_src_sel, .rnd_dir, .rnd_up, .out_valid, .out_result
    );

    // Reference model built from the requirements
    function automatic logic [15:0] lane_model(input logic [15:0] a, input logic [15:0] b,
                                               input logic leg, input logic src,
                                               input logic [1:0] dir, input logic up);
        int s, fl, bump;
        s  = int'($signed(a)) + int'($signed(b));
        fl = s >>> 1;
        bump = 0;
        if ((s & 1) != 0) begin
            if (leg)      bump = 0;
            else if (src) begin
                case (dir)
                    2'd0: bump = 1;
                    2'd1: bump = (s < 0) ? 1 : 0;
                    2'd2: bump = 1;
                    default: bump = 0;
                endcase
            end else bump = up ? 1 : 0;
        end
        return 16'(fl + bump);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic leg,
                        input logic src, input logic [1:0] dir, input logic up,
                        input string tag);
        item_t it;
        @(negedge clk);
        opnd_a = a; opnd_b = b; legacy_mode = leg;
        rnd_src_sel = src; rnd_dir = dir; rnd_up = up; in_valid = 1'b1;
        it.exp = {lane_model(a[31:16], b[31:16], leg, src, dir, up),
                  lane_model(a[15:0],  b[15:0],  leg, src, dir, up)};
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opnd_a = $urandom; opnd_b = $urandom; legacy_mode = 1'($urandom);
            rnd_src_sel = 1'($urandom); rnd_dir = 2'($urandom); rnd_up = 1'($urandom);
        end
    endtask

    // Monitor: compare each presented result against the scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                check("R2 unexpected out_valid", {31'd0, out_valid}, 32'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, out_result, it.exp);
                last_exp = it.exp;
            end
        end
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R3: reset clears outputs even with valid input applied
        @(negedge clk);
        in_valid = 1'b1; opnd_a = 32'h1234_5678; opnd_b = 32'h1111_2222;
        @(negedge clk);
        check("R3 out_valid in reset", {31'd0, out_valid}, 32'd0);
        check("R3 out_result in reset", out_result, 32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // R1: lanes independent and in place (low odd, high even)
        send(32'h0004_0003, 32'h0002_0000, 1'b0, 1'b1, 2'd0, 1'b0, "R1 lane packing");
        send(32'h8000_7FFF, 32'h0000_0001, 1'b0, 1'b1, 2'd2, 1'b0, "R1 lanes isolated");
        // R4: legacy ignores other controls
        send(32'hFFFD_0003, 32'h0000_0000, 1'b1, 1'b1, 2'd2, 1'b1, "R4 legacy src dir");
        send(32'hFFFD_0003, 32'h0000_0000, 1'b1, 1'b0, 2'd0, 1'b1, "R4 legacy rnd_up");
        // R5: even sums exact
        send(32'hFFF0_0010, 32'hFFFE_0006, 1'b0, 1'b1, 2'd0, 1'b0, "R5 even nearest");
        send(32'hFFF0_0010, 32'hFFFE_0006, 1'b0, 1'b0, 2'd0, 1'b1, "R5 even up");
        // R6..R9: direction field, positive and negative odd sums
        send(32'hFFFD_0003, 32'h0000_0000, 1'b0, 1'b1, 2'd0, 1'b0, "R6 nearest");
        send(32'hFFFD_0003, 32'h0000_0000, 1'b0, 1'b1, 2'd1, 1'b0, "R7 toward zero");
        send(32'hFFFB_0005, 32'hFFFE_0002, 1'b0, 1'b1, 2'd1, 1'b1, "R7 toward zero b");
        send(32'hFFFD_0003, 32'h0000_0000, 1'b0, 1'b1, 2'd2, 1'b0, "R8 toward +inf");
        send(32'hFFFD_0003, 32'h0000_0000, 1'b0, 1'b1, 2'd3, 1'b1, "R9 toward -inf");
        // R10: single bit source, field ignored
        send(32'hFFFD_0003, 32'h0000_0000, 1'b0, 1'b0, 2'd1, 1'b1, "R10 rnd_up set");
        send(32'hFFFD_0003, 32'h0000_0000, 1'b0, 1'b0, 2'd2, 1'b0, "R10 rnd_up clear");
        // R11: extremes
        send(32'h7FFF_7FFF, 32'h7FFF_7FFF, 1'b0, 1'b1, 2'd2, 1'b0, "R11 max pair");
        send(32'h8000_8000, 32'h8000_8000, 1'b0, 1'b1, 2'd0, 1'b0, "R11 min pair");
        send(32'h7FFF_8000, 32'h7FFE_8001, 1'b0, 1'b1, 2'd2, 1'b0, "R11 odd near max");
        // R2: hold while idle, then a gap and back-to-back resumes
        idle(3);
        @(negedge clk);
        check("R2 valid low when idle", {31'd0, out_valid}, 32'd0);
        check("R2 result held when idle", out_result, last_exp);
        // R1: random mix over every mode
        for (int i = 0; i < 300; i++) begin
            send($urandom, $urandom, 1'(($urandom % 4) == 0), 1'($urandom),
                 2'($urandom), 1'($urandom), "R1 random");
            if ((i % 7) == 0) idle(1);
        end
        idle(4);
        check("R2 scoreboard drained", sb_q.size(), 32'd0);
        finish_run();
    end

endmodule